// File: doc/BRIEF.md
# Compressed Image Header Stripper

This block sits at the front of a lossless image decompression path. It takes a byte stream that arrives on an AXI4-Stream slave port, five bytes per 40-bit beat with a byte-enable mask, and removes the fixed 14-byte file header at the start of every frame. While the header passes through, the block checks the four-byte signature. It also collects the image width, height, channel count and colorspace and presents them as sideband outputs.

All bytes after the header are payload. The block packs them into dense five-byte words, keeping their order, whatever mix of partial beats they arrived in. The words are written into an internal FIFO. Each FIFO word carries its valid-byte count and an end-of-frame flag. The chunk decoder downstream pops words from the FIFO through a valid/ready read port.

A frame whose signature does not match is discarded up to and including its final beat, and a sticky error flag records the event. The following frame is decoded normally.

Top module: `img_hdr_strip`

## Requirements
- R1: Byte k of an input beat (k = 0..4, byte 0 first in stream order) sits at `s_tdata[39-8k -: 8]` and is valid when `s_tkeep[4-k]` is 1. Valid bytes are contiguous from the top. Bytes whose keep bit is 0 never reach the output.
- R2: The first 14 bytes of every frame never appear on the output port, however they are split across beats.
- R3: Header layout, by byte position within the frame: positions 0..3 must be 0x71 0x6F 0x69 0x66. Positions 4..7 hold the width as a big-endian 32-bit value, and only positions 6 (high) and 7 (low) are kept. Positions 8..11 hold the height the same way, with 10 and 11 kept. Position 12 is the channel count and position 13 is the colorspace.
- R4: The four sideband outputs change together, one clock after the beat holding header byte 13 of a frame with a correct signature is accepted. They hold their values at all other times.
- R5: Payload bytes leave in stream order, packed MSB-first into `m_data`. `m_count` gives the number of valid bytes in the word, and every word other than a frame's last carries exactly 5.
- R6: `m_last` is set on the word that holds the frame's final payload byte and on no other word. A frame that has no payload produces exactly one word with `m_count` = 0 and `m_last` = 1.
- R7: A signature mismatch sets `magic_err`, which stays 1 until reset. No word of that frame is output and the sideband outputs keep their values. The next frame is handled normally.
- R8: `s_tready` is 0 while the FIFO is full and for the single cycle a split final word needs to finish writing. No accepted byte is lost.
- R9: While `m_valid` is 1 and `m_ready` is 0, the output word stays valid and unchanged.
- R10: After reset, `s_tready` is 1, `m_valid` is 0, and the sideband outputs and `magic_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_tdata | input | 40 | Input bytes, byte 0 in the top lane |
| s_tkeep | input | 5 | Byte valid mask, MSB-aligned |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted when high with s_tvalid |
| s_tlast | input | 1 | Final beat of a frame |
| m_data | output | 40 | Packed payload word, first byte in the top lane |
| m_count | output | 3 | Valid bytes in m_data (0..5) |
| m_last | output | 1 | Word ends the frame |
| m_valid | output | 1 | FIFO holds a word |
| m_ready | input | 1 | Consumer pops the word |
| img_width | output | 16 | Image width, low 16 bits |
| img_height | output | 16 | Image height, low 16 bits |
| img_channels | output | 8 | Channel count byte |
| img_colorspace | output | 8 | Colorspace byte |
| magic_err | output | 1 | Sticky signature mismatch flag |

## Verification
The bench builds the block with a FIFO depth of 4 words instead of 64. With that depth, one stalled frame of 40 payload bytes fills the FIFO, so the bench can watch the input-side backpressure and the held output word without long runs. The remaining parameters keep their defaults. Beat-size patterns are chosen so that the header ends mid-beat and a final beat completes the frame with more than five bytes pending, which exercises the extra flush cycle.

// File: rtl/img_hs_pkg.sv
package img_hs_pkg;
  localparam int LANES     = 5;
  localparam int LANE_W    = 8;
  localparam int BEAT_W    = LANES * LANE_W;
  localparam int HDR_LEN   = 14;
  localparam int CNT_W     = 3;

  typedef struct packed {
    logic [BEAT_W-1:0] data;
    logic [CNT_W-1:0]  cnt;
    logic              last;
  } word_t;

  localparam int WORD_W = $bits(word_t);

  function automatic logic [7:0] sig_byte(input logic [1:0] pos);
    case (pos)
      2'd0:    sig_byte = 8'h71;
      2'd1:    sig_byte = 8'h6F;
      2'd2:    sig_byte = 8'h69;
      default: sig_byte = 8'h66;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] lanes_on(input logic [LANES-1:0] keep);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < LANES; i++) n = n + CNT_W'(keep[i]);
    return n;
  endfunction

  function automatic logic [BEAT_W-1:0] clear_unused(input logic [BEAT_W-1:0] d,
                                                    input logic [CNT_W-1:0] n);
    logic [BEAT_W-1:0] r;
    r = '0;
    for (int k = 0; k < LANES; k++)
      if (CNT_W'(k) < n) r[BEAT_W-1-LANE_W*k -: LANE_W] = d[BEAT_W-1-LANE_W*k -: LANE_W];
    return r;
  endfunction
endpackage

// File: rtl/ihs_parser.sv
module ihs_parser
  import img_hs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              beat_fire,
  input  logic [BEAT_W-1:0] beat_data,
  input  logic [CNT_W-1:0]  beat_n,
  input  logic              beat_last,
  output logic [CNT_W-1:0]  hdr_n,
  output logic              drop,
  output logic              pub,
  output logic [15:0]       width,
  output logic [15:0]       height,
  output logic [7:0]        channels,
  output logic [7:0]        colorspace,
  output logic              err
);
  logic [3:0]  pos_q;
  logic        bad_q;
  logic [15:0] st_w_q, st_h_q, st_w_n, st_h_n;
  logic [7:0]  st_c_q, st_s_q, st_c_n, st_s_n;
  logic        mism;
  logic [4:0]  idx;
  logic [7:0]  lane;
  logic [4:0]  reach;
  logic        hdr_end;

  always_comb begin
    hdr_n  = '0;
    mism   = 1'b0;
    st_w_n = st_w_q;
    st_h_n = st_h_q;
    st_c_n = st_c_q;
    st_s_n = st_s_q;
    idx    = '0;
    lane   = '0;
    for (int k = 0; k < LANES; k++) begin
      idx  = 5'(pos_q) + 5'(k);
      lane = beat_data[BEAT_W-1-LANE_W*k -: LANE_W];
      if (CNT_W'(k) < beat_n && idx < 5'(HDR_LEN)) begin
        hdr_n = hdr_n + 3'd1;
        if (idx < 5'd4 && lane != sig_byte(idx[1:0])) mism = 1'b1;
        case (idx)
          5'd6:    st_w_n[15:8] = lane;
          5'd7:    st_w_n[7:0]  = lane;
          5'd10:   st_h_n[15:8] = lane;
          5'd11:   st_h_n[7:0]  = lane;
          5'd12:   st_c_n       = lane;
          5'd13:   st_s_n       = lane;
          default: ;
        endcase
      end
    end
  end

  assign reach   = 5'(pos_q) + 5'(beat_n);
  assign hdr_end = beat_fire && (pos_q < 4'(HDR_LEN)) && (reach >= 5'(HDR_LEN));
  assign drop    = bad_q | mism;
  assign pub     = hdr_end && !drop;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q      <= '0;
      bad_q      <= 1'b0;
      err        <= 1'b0;
      st_w_q     <= '0;
      st_h_q     <= '0;
      st_c_q     <= '0;
      st_s_q     <= '0;
      width      <= '0;
      height     <= '0;
      channels   <= '0;
      colorspace <= '0;
    end else if (beat_fire) begin
      pos_q  <= beat_last ? 4'd0 : ((reach >= 5'(HDR_LEN)) ? 4'(HDR_LEN) : reach[3:0]);
      bad_q  <= beat_last ? 1'b0 : drop;
      err    <= err | mism;
      st_w_q <= st_w_n;
      st_h_q <= st_h_n;
      st_c_q <= st_c_n;
      st_s_q <= st_s_n;
      if (pub) begin
        width      <= st_w_n;
        height     <= st_h_n;
        channels   <= st_c_n;
        colorspace <= st_s_n;
      end
    end
  end

  assert_side_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !pub |=> ($stable(width) && $stable(height) && $stable(channels) && $stable(colorspace)));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  assert_hdr_done_R2: assert property (@(posedge clk) disable iff (rst)
    (beat_fire && pos_q == 4'(HDR_LEN)) |-> (hdr_n == '0));
endmodule

// File: rtl/ihs_packer.sv
module ihs_packer
  import img_hs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_fire,
  input  logic [BEAT_W-1:0] in_data,
  input  logic [CNT_W-1:0]  in_n,
  input  logic [CNT_W-1:0]  hdr_n,
  input  logic              drop,
  input  logic              in_last,
  input  logic              full,
  output logic              push,
  output word_t             word,
  output logic              busy
);
  logic [BEAT_W-1:0]   acc_q;
  logic [CNT_W-1:0]    accn_q;
  logic                flush_q;
  logic [BEAT_W-1:0]   pay;
  logic [CNT_W-1:0]    np;
  logic [2*BEAT_W-1:0] merged;
  logic [3:0]          total;
  logic [3:0]          rest;

  assign pay    = in_data << {hdr_n, 3'b000};
  assign np     = drop ? '0 : (in_n - hdr_n);
  assign merged = {acc_q, {BEAT_W{1'b0}}} | ({pay, {BEAT_W{1'b0}}} >> {accn_q, 3'b000});
  assign total  = 4'(accn_q) + 4'(np);
  assign rest   = total - 4'(LANES);
  assign busy   = flush_q;

  always_comb begin
    push      = 1'b0;
    word.data = merged[2*BEAT_W-1 -: BEAT_W];
    word.cnt  = 3'(LANES);
    word.last = 1'b0;
    if (flush_q) begin
      push      = !full;
      word.data = acc_q;
      word.cnt  = accn_q;
      word.last = 1'b1;
    end else if (in_fire && !drop) begin
      if (in_last) begin
        push      = 1'b1;
        word.cnt  = (total > 4'(LANES)) ? 3'(LANES) : total[2:0];
        word.last = (total <= 4'(LANES));
      end else if (total >= 4'(LANES)) begin
        push = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      accn_q  <= '0;
      flush_q <= 1'b0;
    end else if (flush_q) begin
      if (!full) begin
        acc_q   <= '0;
        accn_q  <= '0;
        flush_q <= 1'b0;
      end
    end else if (in_fire) begin
      if (drop) begin
        if (in_last) begin
          acc_q  <= '0;
          accn_q <= '0;
        end
      end else if (in_last) begin
        if (total > 4'(LANES)) begin
          acc_q   <= merged[BEAT_W-1:0];
          accn_q  <= rest[2:0];
          flush_q <= 1'b1;
        end else begin
          acc_q  <= '0;
          accn_q <= '0;
        end
      end else if (total >= 4'(LANES)) begin
        acc_q  <= merged[BEAT_W-1:0];
        accn_q <= rest[2:0];
      end else begin
        acc_q  <= merged[2*BEAT_W-1 -: BEAT_W];
        accn_q <= total[2:0];
      end
    end
  end

  assert_dense_word_R5: assert property (@(posedge clk) disable iff (rst)
    (push && !word.last) |-> (word.cnt == 3'(LANES)));

  assert_empty_is_last_R6: assert property (@(posedge clk) disable iff (rst)
    (push && word.cnt == '0) |-> word.last);

  assert_no_bad_push_R7: assert property (@(posedge clk) disable iff (rst)
    (in_fire && drop) |-> !push);
endmodule

// File: rtl/ihs_fifo.sv
module ihs_fifo #(
  parameter int WIDTH = 44,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wr_data,
  output logic             full,
  input  logic             pop,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    used_q;
  logic             do_wr, do_rd;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full     = (used_q == CW'(DEPTH));
  assign rd_valid = (used_q != '0);
  assign rd_data  = mem[rp_q];
  assign do_wr    = push && !full;
  assign do_rd    = pop && rd_valid;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q   <= '0;
      rp_q   <= '0;
      used_q <= '0;
    end else begin
      if (do_wr) wp_q <= step(wp_q);
      if (do_rd) rp_q <= step(rp_q);
      if (do_wr && !do_rd)      used_q <= used_q + CW'(1);
      else if (do_rd && !do_wr) used_q <= used_q - CW'(1);
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);

  assert_hold_word_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !pop) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: rtl/img_hdr_strip.sv
module img_hdr_strip
  import img_hs_pkg::*;
#(
  parameter int FIFO_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [39:0] s_tdata,
  input  logic [4:0]  s_tkeep,
  input  logic        s_tvalid,
  output logic        s_tready,
  input  logic        s_tlast,
  output logic [39:0] m_data,
  output logic [2:0]  m_count,
  output logic        m_last,
  output logic        m_valid,
  input  logic        m_ready,
  output logic [15:0] img_width,
  output logic [15:0] img_height,
  output logic [7:0]  img_channels,
  output logic [7:0]  img_colorspace,
  output logic        magic_err
);
  logic [CNT_W-1:0]  beat_n;
  logic [BEAT_W-1:0] beat_d;
  logic              fire;
  logic [CNT_W-1:0]  hdr_n;
  logic              drop, pub;
  logic              push, pk_busy, fifo_full;
  word_t             push_word, pop_word;
  logic [WORD_W-1:0] pop_bits;

  assign beat_n   = lanes_on(s_tkeep);
  assign beat_d   = clear_unused(s_tdata, beat_n);
  assign s_tready = !fifo_full && !pk_busy;
  assign fire     = s_tvalid && s_tready;

  ihs_parser u_parse (
    .clk(clk), .rst(rst), .beat_fire(fire), .beat_data(beat_d), .beat_n(beat_n),
    .beat_last(s_tlast), .hdr_n(hdr_n), .drop(drop), .pub(pub),
    .width(img_width), .height(img_height), .channels(img_channels),
    .colorspace(img_colorspace), .err(magic_err)
  );

  ihs_packer u_pack (
    .clk(clk), .rst(rst), .in_fire(fire), .in_data(beat_d), .in_n(beat_n),
    .hdr_n(hdr_n), .drop(drop), .in_last(s_tlast), .full(fifo_full),
    .push(push), .word(push_word), .busy(pk_busy)
  );

  ihs_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .wr_data(push_word), .full(fifo_full),
    .pop(m_ready), .rd_valid(m_valid), .rd_data(pop_bits)
  );

  assign pop_word = pop_bits;
  assign m_data   = pop_word.data;
  assign m_count  = pop_word.cnt;
  assign m_last   = pop_word.last;

  assert_out_empty_R6: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_count == 3'd0) |-> m_last);

  assert_out_count_R5: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> (m_count <= 3'd5));

  assert_pub_on_beat_R4: assert property (@(posedge clk) disable iff (rst)
    pub |-> fire);
endmodule

// File: tb/img_hdr_strip_tb.sv
module img_hdr_strip_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [39:0] s_tdata = '0;
  logic [4:0]  s_tkeep = '0;
  logic        s_tvalid = 1'b0;
  logic        s_tready;
  logic        s_tlast = 1'b0;
  logic [39:0] m_data;
  logic [2:0]  m_count;
  logic        m_last, m_valid;
  logic        m_ready = 1'b0;
  logic [15:0] img_width, img_height;
  logic [7:0]  img_channels, img_colorspace;
  logic        magic_err;

  int n_chk = 0;
  int n_fail = 0;
  bit stall_out = 1'b0;

  logic [39:0] q_d[$];
  int          q_n[$];
  bit          q_l[$];

  always #2.5 clk = ~clk;

  img_hdr_strip #(.FIFO_DEPTH(4)) u_dut (
    .clk(clk), .rst(rst), .s_tdata(s_tdata), .s_tkeep(s_tkeep), .s_tvalid(s_tvalid),
    .s_tready(s_tready), .s_tlast(s_tlast), .m_data(m_data), .m_count(m_count),
    .m_last(m_last), .m_valid(m_valid), .m_ready(m_ready), .img_width(img_width),
    .img_height(img_height), .img_channels(img_channels),
    .img_colorspace(img_colorspace), .magic_err(magic_err)
  );

  initial begin
    forever begin
      @(negedge clk);
      m_ready = !stall_out;
      if (m_valid && m_ready) begin
        q_d.push_back(m_data);
        q_n.push_back(int'(m_count));
        q_l.push_back(m_last);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // one beat; entered and left at a negedge
  task automatic send_beat(input logic [39:0] d, input int n, input bit last);
    s_tdata  = d;
    s_tkeep  = 5'(5'h1F << (5 - n));
    s_tvalid = 1'b1;
    s_tlast  = last;
    while (!s_tready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] fb[$], input int sizes[$]);
    int pos = 0;
    int si = 0;
    while (pos < fb.size()) begin
      int n = sizes[si % sizes.size()];
      logic [39:0] d = {5{8'hA5}};  // garbage in unused lanes (R1)
      if (n > fb.size() - pos) n = fb.size() - pos;
      for (int k = 0; k < n; k++) d[39-8*k -: 8] = fb[pos+k];
      send_beat(d, n, (pos + n) == fb.size());
      pos += n;
      si++;
    end
  endtask

  function automatic void make_frame(ref logic [7:0] fb[$], input logic [31:0] w,
                                     input logic [31:0] h, input logic [7:0] ch,
                                     input logic [7:0] cs, input logic [7:0] sig3,
                                     input int plen, input logic [7:0] seed);
    fb = {};
    fb.push_back(8'h71); fb.push_back(8'h6F); fb.push_back(8'h69); fb.push_back(sig3);
    for (int i = 3; i >= 0; i--) fb.push_back(w[8*i +: 8]);
    for (int i = 3; i >= 0; i--) fb.push_back(h[8*i +: 8]);
    fb.push_back(ch);
    fb.push_back(cs);
    for (int i = 0; i < plen; i++) fb.push_back(8'(seed + 8'(i * 7)));
  endfunction

  task automatic drain();
    repeat (30) @(negedge clk);
  endtask

  task automatic clear_q();
    q_d = {}; q_n = {}; q_l = {};
  endtask

  // expected words: payload in chunks of five, remainder on the last word
  task automatic expect_words(input logic [7:0] fb[$], input string req);
    int plen = fb.size() - 14;
    int nw = (plen == 0) ? 1 : (plen + 4) / 5;
    chk(q_d.size() == nw, req, "word count", 64'(q_d.size()), 64'(nw));
    for (int w = 0; w < nw && w < q_d.size(); w++) begin
      logic [39:0] ed = '0;
      int en = plen - 5 * w;
      if (en > 5) en = 5;
      for (int k = 0; k < en; k++) ed[39-8*k -: 8] = fb[14 + 5*w + k];
      chk(q_d[w] == ed, req, $sformatf("word %0d data", w), 64'(q_d[w]), 64'(ed));
      chk(q_n[w] == en, "R5", $sformatf("word %0d count", w), 64'(q_n[w]), 64'(en));
      chk(q_l[w] == (w == nw - 1), "R6", $sformatf("word %0d last", w),
          64'(q_l[w]), 64'(w == nw - 1));
    end
  endtask

  task automatic expect_side(input logic [15:0] w, input logic [15:0] h,
                             input logic [7:0] c, input logic [7:0] s, input string req);
    chk(img_width == w, req, "width", 64'(img_width), 64'(w));
    chk(img_height == h, req, "height", 64'(img_height), 64'(h));
    chk(img_channels == c, req, "channels", 64'(img_channels), 64'(c));
    chk(img_colorspace == s, req, "colorspace", 64'(img_colorspace), 64'(s));
  endtask

  task automatic t_reset();
    chk(s_tready == 1'b1, "R10", "tready", 64'(s_tready), 64'd1);
    chk(m_valid == 1'b0, "R10", "m_valid", 64'(m_valid), 64'd0);
    chk(magic_err == 1'b0, "R10", "magic_err", 64'(magic_err), 64'd0);
    expect_side(16'h0, 16'h0, 8'h0, 8'h0, "R10");
  endtask

  // full beats: header ends inside the third beat (R2, R3)
  task automatic t_full_beats();
    logic [7:0] fb[$];
    make_frame(fb, 32'h1234_0140, 32'h0055_00F0, 8'd4, 8'd0, 8'h66, 23, 8'h10);
    clear_q();
    send_frame(fb, {5});
    drain();
    expect_words(fb, "R2");
    expect_side(16'h0140, 16'h00F0, 8'd4, 8'd0, "R3");
  endtask

  // sideband timing and partial-keep repacking (R1, R4, R5)
  task automatic t_partial();
    logic [7:0] fb[$];
    make_frame(fb, 32'hFFFF_0321, 32'h0001_0222, 8'd3, 8'd1, 8'h66, 17, 8'h40);
    clear_q();
    send_beat({fb[0], fb[1], fb[2], fb[3], fb[4]}, 5, 1'b0);
    send_beat({fb[5], fb[6], fb[7], fb[8], fb[9]}, 5, 1'b0);
    send_beat({fb[10], fb[11], fb[12], 16'hBEEF}, 3, 1'b0);
    expect_side(16'h0140, 16'h00F0, 8'd4, 8'd0, "R4");
    send_beat({fb[13], 32'hDEADBEEF}, 1, 1'b0);
    expect_side(16'h0321, 16'h0222, 8'd3, 8'd1, "R4");
    fb = fb[0:13];
    make_frame(fb, 32'hFFFF_0321, 32'h0001_0222, 8'd3, 8'd1, 8'h66, 17, 8'h40);
    begin
      logic [7:0] pl[$];
      pl = fb[14:$];
      send_frame(pl, {3, 1, 4, 2});
    end
    drain();
    expect_words(fb, "R1");
  endtask

  // final beat leaves nine bytes pending: split final word (R6, R8)
  task automatic t_flush();
    logic [7:0] fb[$];
    make_frame(fb, 32'h0000_0010, 32'h0000_0020, 8'd4, 8'd1, 8'h66, 9, 8'h77);
    clear_q();
    send_frame(fb, {5, 5, 4, 4, 5});
    drain();
    expect_words(fb, "R6");
  endtask

  task automatic t_empty();
    logic [7:0] fb[$];
    make_frame(fb, 32'h0000_0002, 32'h0000_0003, 8'd3, 8'd0, 8'h66, 0, 8'h00);
    clear_q();
    send_frame(fb, {5, 5, 4});
    drain();
    expect_words(fb, "R6");
    expect_side(16'h0002, 16'h0003, 8'd3, 8'd0, "R4");
  endtask

  task automatic t_bad_magic();
    logic [7:0] fb[$];
    make_frame(fb, 32'h0000_0999, 32'h0000_0888, 8'd4, 8'd1, 8'h78, 12, 8'h33);
    clear_q();
    send_frame(fb, {5});
    drain();
    chk(magic_err == 1'b1, "R7", "magic_err set", 64'(magic_err), 64'd1);
    chk(q_d.size() == 0, "R7", "words from bad frame", 64'(q_d.size()), 64'd0);
    expect_side(16'h0002, 16'h0003, 8'd3, 8'd0, "R7");
    make_frame(fb, 32'h0000_0444, 32'h0000_0555, 8'd4, 8'd0, 8'h66, 7, 8'h90);
    clear_q();
    send_frame(fb, {4, 3});
    drain();
    expect_words(fb, "R7");
    expect_side(16'h0444, 16'h0555, 8'd4, 8'd0, "R7");
    chk(magic_err == 1'b1, "R7", "magic_err sticky", 64'(magic_err), 64'd1);
  endtask

  task automatic t_backpressure();
    logic [7:0] fb[$];
    bit saw_low = 1'b0;
    logic [39:0] held;
    make_frame(fb, 32'h0000_0008, 32'h0000_0008, 8'd4, 8'd0, 8'h66, 40, 8'h05);
    clear_q();
    stall_out = 1'b1;
    fork
      send_frame(fb, {5});
      begin
        for (int c = 0; c < 40; c++) begin
          @(negedge clk);
          if (s_tvalid && !s_tready) saw_low = 1'b1;
          if (c == 30) held = m_data;
        end
        @(negedge clk);
        chk(m_valid == 1'b1, "R9", "valid held", 64'(m_valid), 64'd1);
        chk(m_data == held, "R9", "data held", 64'(m_data), 64'(held));
        stall_out = 1'b0;
      end
    join
    drain();
    chk(saw_low, "R8", "tready low on full FIFO", 64'(saw_low), 64'd1);
    expect_words(fb, "R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full_beats();
    t_partial();
    t_flush();
    t_empty();
    t_bad_magic();
    t_backpressure();
    finish_run();
  end
endmodule